// File: doc/BRIEF.md
# Masked GPIO Bank with Automatic Transmit/Receive Override

This block drives two 16-pin general-purpose I/O groups, one for the transmit side and one for the receive side of a radio front end. Each group has an output-enable register and an output-value register. Every write to either register carries a per-bit mask in its upper half, so software can change a few pins without reading the register first.

An automatic transmit/receive overlay can take over chosen pins. It drives them to a stored transmit pattern while `tx_active` is high and to a stored receive pattern while it is low. A single readback word returns the level of every pin in both groups. Inputs are synchronised before they are read. A driven pin reads back the value it drives.

Software uses a simple strobe-and-address write port and a read port with one cycle of latency. A shutdown input turns every pin into an input in a single cycle.

Top module: `gpio_bank_atr`

## Requirements
- R1: While `rst` is high, on the next clock edge all output enables, all pin outputs and `rd_data` become zero, and every configuration register reads back as zero.
- R2: A write to an output-enable register (address 0 = transmit group, 1 = receive group) updates only the bits whose mask bit `wr_data[31:16]` is 1, taking them from `wr_data[15:0]`. The new value appears on that group's `*_pin_oe` right after the write edge, and the other group is unchanged.
- R3: A write to an output-value register (address 2 = transmit group, 3 = receive group) uses the same masked update. The group's driven outputs reflect the new value one clock edge after the register changes.
- R4: Each group has three override registers, written whole from `wr_data[15:0]`: mask (addresses 4/5), transmit pattern (6/7) and receive pattern (8/9), with transmit group first. On each edge, every pin whose override mask bit is 1 registers the transmit pattern bit if `tx_active` is high and the receive pattern bit if it is low.
- R5: Pins whose override mask bit is 0, including every pin when the mask is zero, register the output-value register bit, and the stored patterns have no effect on them.
- R6: Reading address 10 returns the receive group's pin levels in bits 31:16 and the transmit group's in bits 15:0. A pin whose output enable is 1 reads back its driven output, and a pin whose output enable is 0 reads back its synchronised input.
- R7: A pin input passes through two flip-flops. A read sampled at the first or second edge after an input change returns the old level, and a read at the third edge returns the new level.
- R8: `rd_data` is registered on the edge at which `rd_en` is high and holds its value otherwise. Addresses 0 to 9 return that register in bits 15:0 with zeros above, and any address above 10 returns zero.
- R9: Writes to addresses above 9 change no register and no pin.
- R10: `shutdown` high at an edge clears both output-enable registers, with priority over a write in the same cycle. The output-value and override registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shutdown | input | 1 | Clears all output enables |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 32 | Mask in 31:16, value in 15:0 |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 32 | Read result, one cycle after the strobe |
| tx_active | input | 1 | Selects the override transmit pattern when high |
| tx_pin_in | input | 16 | Transmit group pad inputs |
| tx_pin_oe | output | 16 | Transmit group output enables |
| tx_pin_out | output | 16 | Transmit group output values |
| rx_pin_in | input | 16 | Receive group pad inputs |
| rx_pin_oe | output | 16 | Receive group output enables |
| rx_pin_out | output | 16 | Receive group output values |

## Verification
Fixed patterns come first. Overlapping masked writes show that unmasked bits hold. A partial override mask shows that override pins and plain pins are chosen per bit, and toggling `tx_active` shows which stored pattern is picked. A mix of driven and undriven pins in the readback word separates the driven level from the synchronised input, and a single input step read on three consecutive edges pins down the synchroniser depth. A long random phase follows, with random addresses including unknown ones, random masks, reads, shutdown pulses and `tx_active` toggles. It is compared every clock against a behavioural model, which exposes cross-group leaks and errors in the priority between shutdown and a write.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;
  localparam int NUM_GROUPS = 2;
  localparam int GRP_TX     = 0;
  localparam int GRP_RX     = 1;

  // Register kinds held per group; address = kind * NUM_GROUPS + group
  typedef enum int {
    K_OE    = 0,
    K_IO    = 1,
    K_AMASK = 2,
    K_ATXV  = 3,
    K_ARXV  = 4
  } reg_kind_e;

  localparam int REG_KINDS = 5;
  localparam int RB_ADDR   = REG_KINDS * NUM_GROUPS;

  function automatic int reg_addr(int grp, int kind);
    return kind * NUM_GROUPS + grp;
  endfunction
endpackage

// File: rtl/gpio_masked_reg.sv
module gpio_masked_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (wr) begin
      q <= (q & ~mask) | (val & mask);
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_group.sv
module gpio_pin_group
  import gpio_atr_pkg::*;
#(
  parameter int PIN_W       = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int GRP         = 0
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            shutdown,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [PIN_W-1:0]                wr_mask,
  input  logic [PIN_W-1:0]                wr_val,
  input  logic                            tx_active,
  input  logic [PIN_W-1:0]                pin_in,
  output logic [PIN_W-1:0]                pin_oe,
  output logic [PIN_W-1:0]                pin_out,
  output logic [PIN_W-1:0]                level,
  output logic [REG_KINDS-1:0][PIN_W-1:0] regs_q
);
  localparam logic [PIN_W-1:0] ALL_ONES = '1;

  // One register per kind; enables are cleared by shutdown, override regs take whole words
  for (genvar k = 0; k < REG_KINDS; k++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(reg_addr(GRP, k));
    localparam bit MASKED = (k == int'(K_OE)) || (k == int'(K_IO));
    localparam bit CLEARS = (k == int'(K_OE));
    logic hit;
    assign hit = wr_en && (wr_addr == MY_ADDR);
    gpio_masked_reg #(.W(PIN_W)) u_reg (
      .clk  (clk),
      .rst  (rst),
      .clr  (CLEARS ? shutdown : 1'b0),
      .wr   (hit),
      .mask (MASKED ? wr_mask : ALL_ONES),
      .val  (wr_val),
      .q    (regs_q[k])
    );
  end

  logic [PIN_W-1:0] oe_q, io_q, am_q, atx_q, arx_q;
  assign oe_q  = regs_q[K_OE];
  assign io_q  = regs_q[K_IO];
  assign am_q  = regs_q[K_AMASK];
  assign atx_q = regs_q[K_ATXV];
  assign arx_q = regs_q[K_ARXV];

  logic [PIN_W-1:0] atr_sel, out_d, out_q;
  always_comb begin
    atr_sel = tx_active ? atx_q : arx_q;
    out_d   = (am_q & atr_sel) | (~am_q & io_q);
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= out_d;
  end

  logic [PIN_W-1:0] in_sync;
  gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (in_sync)
  );

  assign pin_oe  = oe_q;
  assign pin_out = out_q;
  assign level   = (oe_q & out_q) | (~oe_q & in_sync);
endmodule

// File: rtl/gpio_bank_atr.sv
module gpio_bank_atr
  import gpio_atr_pkg::*;
#(
  parameter int PIN_W       = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shutdown,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [2*PIN_W-1:0]   wr_data,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [2*PIN_W-1:0]   rd_data,
  input  logic                 tx_active,
  input  logic [PIN_W-1:0]     tx_pin_in,
  output logic [PIN_W-1:0]     tx_pin_oe,
  output logic [PIN_W-1:0]     tx_pin_out,
  input  logic [PIN_W-1:0]     rx_pin_in,
  output logic [PIN_W-1:0]     rx_pin_oe,
  output logic [PIN_W-1:0]     rx_pin_out
);
  localparam int DATA_W = 2 * PIN_W;
  localparam logic [ADDR_W-1:0] RB_A = ADDR_W'(RB_ADDR);

  logic [PIN_W-1:0] wr_mask, wr_val;
  assign wr_mask = wr_data[DATA_W-1:PIN_W];
  assign wr_val  = wr_data[PIN_W-1:0];

  logic [NUM_GROUPS-1:0][PIN_W-1:0]                grp_in, grp_oe, grp_out, grp_lvl;
  logic [NUM_GROUPS-1:0][REG_KINDS-1:0][PIN_W-1:0] grp_regs;

  assign grp_in[GRP_TX] = tx_pin_in;
  assign grp_in[GRP_RX] = rx_pin_in;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    gpio_pin_group #(
      .PIN_W       (PIN_W),
      .ADDR_W      (ADDR_W),
      .SYNC_STAGES (SYNC_STAGES),
      .GRP         (g)
    ) u_grp (
      .clk       (clk),
      .rst       (rst),
      .shutdown  (shutdown),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_mask   (wr_mask),
      .wr_val    (wr_val),
      .tx_active (tx_active),
      .pin_in    (grp_in[g]),
      .pin_oe    (grp_oe[g]),
      .pin_out   (grp_out[g]),
      .level     (grp_lvl[g]),
      .regs_q    (grp_regs[g])
    );
  end

  assign tx_pin_oe  = grp_oe[GRP_TX];
  assign tx_pin_out = grp_out[GRP_TX];
  assign rx_pin_oe  = grp_oe[GRP_RX];
  assign rx_pin_out = grp_out[GRP_RX];

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (rd_addr == RB_A) begin
      rd_next = {grp_lvl[GRP_RX], grp_lvl[GRP_TX]};
    end
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int k = 0; k < REG_KINDS; k++) begin
        if (rd_addr == ADDR_W'(reg_addr(g, k))) begin
          rd_next = {{PIN_W{1'b0}}, grp_regs[g][k]};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/gpio_bank_atr_chk.sv
module gpio_bank_atr_chk
  import gpio_atr_pkg::*;
#(
  parameter int PIN_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic                                      clk,
  input logic                                      rst,
  input logic                                      shutdown,
  input logic                                      wr_en,
  input logic [ADDR_W-1:0]                         wr_addr,
  input logic [2*PIN_W-1:0]                        wr_data,
  input logic                                      rd_en,
  input logic [ADDR_W-1:0]                         rd_addr,
  input logic [2*PIN_W-1:0]                        rd_data,
  input logic                                      tx_active,
  input logic [PIN_W-1:0]                          tx_pin_oe,
  input logic [PIN_W-1:0]                          tx_pin_out,
  input logic [PIN_W-1:0]                          rx_pin_oe,
  input logic [NUM_GROUPS-1:0][REG_KINDS-1:0][PIN_W-1:0] grp_regs
);
  localparam logic [ADDR_W-1:0] A_TX_OE = ADDR_W'(reg_addr(GRP_TX, K_OE));
  localparam logic [ADDR_W-1:0] A_RB    = ADDR_W'(RB_ADDR);
  localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(RB_ADDR - 1);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (tx_pin_oe == '0 && rx_pin_oe == '0 && rd_data == '0));

  // R2
  masked_oe_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_TX_OE && !shutdown) |=>
      tx_pin_oe == (($past(tx_pin_oe) & ~$past(wr_data[2*PIN_W-1:PIN_W])) |
                    ($past(wr_data[PIN_W-1:0]) & $past(wr_data[2*PIN_W-1:PIN_W]))));

  // R4
  atr_select_chk: assert property (@(posedge clk) disable iff (rst)
    (grp_regs[GRP_TX][K_AMASK] != '0) |=>
      ((tx_pin_out & $past(grp_regs[GRP_TX][K_AMASK])) ==
       (($past(tx_active) ? $past(grp_regs[GRP_TX][K_ATXV]) : $past(grp_regs[GRP_TX][K_ARXV]))
        & $past(grp_regs[GRP_TX][K_AMASK]))));

  // R5
  no_override_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (grp_regs[GRP_TX][K_AMASK] == '0) |=> tx_pin_out == $past(grp_regs[GRP_TX][K_IO]));

  // R8
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R8
  unknown_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr > A_RB) |=> rd_data == '0);

  // R9
  unknown_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > A_LAST && !shutdown) |=> ($stable(tx_pin_oe) && $stable(rx_pin_oe)
      && $stable(grp_regs)));

  // R10
  shutdown_clears_chk: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (tx_pin_oe == '0 && rx_pin_oe == '0));
endmodule

bind gpio_bank_atr gpio_bank_atr_chk #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .shutdown   (shutdown),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .tx_active  (tx_active),
  .tx_pin_oe  (tx_pin_oe),
  .tx_pin_out (tx_pin_out),
  .rx_pin_oe  (rx_pin_oe),
  .grp_regs   (grp_regs)
);

// File: tb/sim_gpio_bank_atr.sv
`timescale 1ns/1ps
module sim_gpio_bank_atr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        shutdown = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tx_active = 1'b0;
  logic [15:0] tx_pin_in = '0, rx_pin_in = '0;
  logic [15:0] tx_pin_oe, tx_pin_out, rx_pin_oe, rx_pin_out;

  always #5 clk = ~clk;

  gpio_bank_atr u0 (
    .clk(clk), .rst(rst), .shutdown(shutdown),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_active(tx_active),
    .tx_pin_in(tx_pin_in), .tx_pin_oe(tx_pin_oe), .tx_pin_out(tx_pin_out),
    .rx_pin_in(rx_pin_in), .rx_pin_oe(rx_pin_oe), .rx_pin_out(rx_pin_out)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: reg[group][kind], address = kind*2 + group
  logic [15:0] m_reg [2][5];
  logic [15:0] m_out [2];
  logic [15:0] m_s1 [2];
  logic [15:0] m_s2 [2];
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < 2; g++) begin
        for (int k = 0; k < 5; k++) m_reg[g][k] = '0;
        m_out[g] = '0; m_s1[g] = '0; m_s2[g] = '0;
      end
      m_rd = '0;
    end else begin
      logic [15:0] lvl [2];
      logic [15:0] pin [2];
      pin[0] = tx_pin_in; pin[1] = rx_pin_in;
      for (int g = 0; g < 2; g++)
        lvl[g] = (m_reg[g][0] & m_out[g]) | (~m_reg[g][0] & m_s2[g]);
      if (rd_en) begin
        if (rd_addr == 4'd10)    m_rd = {lvl[1], lvl[0]};
        else if (rd_addr < 4'd10) m_rd = {16'h0, m_reg[rd_addr % 2][rd_addr / 2]};
        else                     m_rd = '0;
      end
      for (int g = 0; g < 2; g++) begin
        logic [15:0] pat;
        pat = tx_active ? m_reg[g][3] : m_reg[g][4];
        m_out[g] = (m_reg[g][2] & pat) | (~m_reg[g][2] & m_reg[g][1]);
        m_s2[g] = m_s1[g];
        m_s1[g] = pin[g];
      end
      if (wr_en && wr_addr < 4'd10) begin
        int g, k;
        g = wr_addr % 2; k = wr_addr / 2;
        if (k < 2) m_reg[g][k] = (m_reg[g][k] & ~wr_data[31:16]) | (wr_data[15:0] & wr_data[31:16]);
        else       m_reg[g][k] = wr_data[15:0];
      end
      if (shutdown) begin
        m_reg[0][0] = '0; m_reg[1][0] = '0;
      end
    end
  end

  // Every-cycle comparison, away from both clock edges
  always @(posedge clk) begin
    #3;
    if (!done) begin
      chk("R2 R10", "tx_pin_oe", {16'h0, tx_pin_oe}, {16'h0, m_reg[0][0]});
      chk("R2 R10", "rx_pin_oe", {16'h0, rx_pin_oe}, {16'h0, m_reg[1][0]});
      chk("R3 R4 R5", "tx_pin_out", {16'h0, tx_pin_out}, {16'h0, m_out[0]});
      chk("R3 R4 R5", "rx_pin_out", {16'h0, rx_pin_out}, {16'h0, m_out[1]});
      chk("R6 R7 R8", "rd_data", rd_data, m_rd);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "tx_pin_oe", {16'h0, tx_pin_oe}, 32'h0);
    chk("R1", "rx_pin_out", {16'h0, rx_pin_out}, 32'h0);
    chk("R1", "rd_data", rd_data, 32'h0);
    // R2: overlapping masked writes
    wr(4'd0, 32'h00F0_FFFF);
    chk("R2", "tx oe first", {16'h0, tx_pin_oe}, 32'h0000_00F0);
    wr(4'd0, 32'h0030_0000);
    chk("R2", "tx oe masked", {16'h0, tx_pin_oe}, 32'h0000_00C0);
    chk("R2", "rx oe untouched", {16'h0, rx_pin_oe}, 32'h0);
    // R3 / R5: value register with override mask zero
    wr(4'd2, 32'hFFFF_A5A5);
    @(negedge clk);
    chk("R3", "tx out follows io", {16'h0, tx_pin_out}, 32'h0000_A5A5);
    wr(4'd6, 32'h0000_0003);
    wr(4'd8, 32'h0000_000C);
    @(negedge clk);
    chk("R5", "patterns ignored with zero mask", {16'h0, tx_pin_out}, 32'h0000_A5A5);
    // R4: partial override
    wr(4'd4, 32'h0000_000F);
    tx_active = 1'b1;
    @(negedge clk);
    chk("R4", "tx pattern", {16'h0, tx_pin_out}, 32'h0000_A5A3);
    tx_active = 1'b0;
    @(negedge clk);
    chk("R4", "rx pattern", {16'h0, tx_pin_out}, 32'h0000_A5AC);
    // R6: readback mixes driven and input levels
    rx_pin_in = 16'h1234; tx_pin_in = 16'h0000;
    repeat (3) @(negedge clk);
    rd(4'd10);
    chk("R6", "readback word", rd_data, 32'h1234_0080);
    // R7: synchroniser depth
    rx_pin_in = 16'h4321; rd_en = 1'b1; rd_addr = 4'd10;
    @(negedge clk);
    chk("R7", "first edge old", rd_data, 32'h1234_0080);
    @(negedge clk);
    chk("R7", "second edge old", rd_data, 32'h1234_0080);
    @(negedge clk);
    chk("R7", "third edge new", rd_data, 32'h4321_0080);
    rd_en = 1'b0;
    // R8: hold, register read, unknown read
    repeat (2) @(negedge clk);
    chk("R8", "hold without strobe", rd_data, 32'h4321_0080);
    rd(4'd0);
    chk("R8", "register read", rd_data, 32'h0000_00C0);
    rd(4'd15);
    chk("R8", "unknown read", rd_data, 32'h0);
    // R9: unknown write ignored
    wr(4'd12, 32'hFFFF_FFFF);
    rd(4'd0);
    chk("R9", "oe after unknown write", rd_data, 32'h0000_00C0);
    rd(4'd2);
    chk("R9", "io after unknown write", rd_data, 32'h0000_A5A5);
    // R10: shutdown beats a same-cycle write, keeps other registers
    @(negedge clk); shutdown = 1'b1; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'hFFFF_FFFF;
    @(negedge clk); shutdown = 1'b0; wr_en = 1'b0;
    chk("R10", "tx oe cleared", {16'h0, tx_pin_oe}, 32'h0);
    chk("R10", "rx oe cleared", {16'h0, rx_pin_oe}, 32'h0);
    rd(4'd4);
    chk("R10", "override mask kept", rd_data, 32'h0000_000F);
    // Random phase against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en     = ($urandom_range(0, 2) == 0);
      wr_addr   = 4'($urandom_range(0, 15));
      wr_data   = $urandom;
      rd_en     = ($urandom_range(0, 1) == 0);
      rd_addr   = 4'($urandom_range(0, 15));
      tx_active = ($urandom_range(0, 3) == 0) ? ~tx_active : tx_active;
      shutdown  = ($urandom_range(0, 40) == 0);
      tx_pin_in = 16'($urandom);
      rx_pin_in = 16'($urandom);
      rst       = (i == 1500);
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; shutdown = 1'b0; rst = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule